// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is a 32-pin general-purpose I/O port controlled through a simple word-wide register bus. The bus has an address, a write strobe, write data and read data. Inside the port there are three registers: an output-value latch, a per-pin direction register, and a synchronised sample of the pin inputs. Each pin drives an output-enable and an output value, and each pin has an input that the port samples.

Software changes single output bits without a read-modify-write. It does this through three alias offsets. A write to an alias sets, clears or inverts exactly the output bits whose write-data bits are 1. A full write to the output latch still replaces all 32 bits at once. Reads are combinational from the presented address.

Reset is asynchronous and active-low. Its release is expected to be synchronous to `clk`. Offsets that decode to no register read as zero, and writes to them have no effect.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, `pin_out` and `pin_oe` are all zero, and offsets 0x00 and 0x14 read zero.
- R2: A write to offset 0x00 replaces all 32 output bits with the write data. The new value appears on `pin_out` and reads back at 0x00 in the following cycle.
- R3: A write to offset 0x04 forces to 1 each output bit whose write-data bit is 1. All other output bits keep their value.
- R4: A write to offset 0x08 forces to 0 each output bit whose write-data bit is 1. All other output bits keep their value.
- R5: A write to offset 0x0C inverts each output bit whose write-data bit is 1. All other output bits keep their value.
- R6: Offsets 0x04, 0x08 and 0x0C always read as zero.
- R7: Offset 0x10 returns `pin_in` through a two-flop synchroniser. A level applied before a clock edge is readable after the second rising edge, and not after the first. Writes to 0x10 change neither `pin_out` nor `pin_oe`.
- R8: Offset 0x14 is the direction register, and it reads back what was written. Bit n = 1 makes pin n an output, and `pin_oe[n]` equals that bit from the cycle after the write.
- R9: Any address that is not one of 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 reads zero, and a write to it changes no register. This includes any address whose low two bits are nonzero.
- R10: In a cycle with `bus_we` low, `pin_out` and `pin_oe` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Per-pin output value |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
Several properties are checked every cycle by the embedded assertions:
- the set, clear, toggle and full-write update rules on the output latch;
- the direction register capturing its write;
- both registers holding when no write occurs;
- the aliases and undecoded offsets returning zero.

The bench's scenarios show what no single-cycle relation covers:
- the exact two-edge latency of the input synchroniser;
- sequences of alias operations accumulating onto one latch value;
- a sweep over every undecoded address, showing that writes there leave both registers untouched.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Word index of each register (byte offset / 4).
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_SET  = 1;
  localparam int unsigned IDX_CLR  = 2;
  localparam int unsigned IDX_TOG  = 3;
  localparam int unsigned IDX_IN   = 4;
  localparam int unsigned IDX_DIR  = 5;

  // One-hot register select produced by the address decoder.
  typedef struct packed {
    logic data;
    logic set;
    logic clr;
    logic tog;
    logic inp;
    logic dir;
  } reg_sel_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];

  always_comb begin
    sel      = '0;
    sel.data = aligned && (word == WORD_W'(IDX_DATA));
    sel.set  = aligned && (word == WORD_W'(IDX_SET));
    sel.clr  = aligned && (word == WORD_W'(IDX_CLR));
    sel.tog  = aligned && (word == WORD_W'(IDX_TOG));
    sel.inp  = aligned && (word == WORD_W'(IDX_IN));
    sel.dir  = aligned && (word == WORD_W'(IDX_DIR));
  end

  always_comb begin
    assert ($onehot0(sel)) else $error("AST_SEL_ONEHOT"); // R9
  end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  reg_sel_t         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  assign q_en = we && (sel.data || sel.set || sel.clr || sel.tog);

  always_comb begin
    q_nxt = q;
    if (sel.data)     q_nxt = wdata;
    else if (sel.set) q_nxt = q | wdata;
    else if (sel.clr) q_nxt = q & ~wdata;
    else if (sel.tog) q_nxt = q ^ wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel.data) |=> (q == $past(wdata))); // R2
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel.set) |=> (q == ($past(q) | $past(wdata)))); // R3
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel.clr) |=> (q == ($past(q) & ~$past(wdata)))); // R4
  AST_TOG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel.tog) |=> (q == ($past(q) ^ $past(wdata)))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> $stable(q)); // R10

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  reg_sel_t         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic             d_en;
  logic [WIDTH-1:0] d_nxt;

  assign d_en  = we && sel.dir;
  assign d_nxt = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (d_en) q <= d_nxt;
  end

  AST_DIR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel.dir) |=> (q == $past(wdata))); // R8
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(we && sel.dir)) |=> $stable(q)); // R9

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PINS      = 32,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  reg_sel_t        sel;
  logic [PINS-1:0] out_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] in_s;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_out_latch #(.WIDTH(PINS)) out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .sel   (sel),
    .wdata (bus_wdata),
    .q     (out_q)
  );

  gpio_dir_reg #(.WIDTH(PINS)) dir_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .sel   (sel),
    .wdata (bus_wdata),
    .q     (dir_q)
  );

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STGS)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (in_s)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel.data) bus_rdata = out_q;
    if (sel.inp)  bus_rdata = in_s;
    if (sel.dir)  bus_rdata = dir_q;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.set || sel.clr || sel.tog) |-> (bus_rdata == '0)); // R6
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (bus_rdata == '0)); // R9
  AST_INREG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel.inp) |=> ($stable(pin_out) && $stable(pin_oe))); // R7
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we) |=> $stable(pin_oe)); // R10

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_out = '0;
  logic [31:0] exp_dir = '0;

  always #2 clk = ~clk;

  gpio_port_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_state(input string req);
    logic [31:0] v;
    chk({req, " pin_out"}, pin_out, exp_out);
    chk({req, " pin_oe"},  pin_oe,  exp_dir);
    rd(8'h00, v); chk({req, " read 0x00"}, v, exp_out);
    rd(8'h14, v); chk({req, " read 0x14"}, v, exp_dir);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] p;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    #1;
    // R1: outputs zero while reset is asserted
    chk("R1 out in reset", pin_out, '0);
    chk("R1 oe in reset",  pin_oe,  '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after reset");

    // R2..R5, R8: sweep patterns through every write path
    for (int i = 0; i < 24; i++) begin
      p = (i * 32'h9E3779B9) ^ (32'h1 << i);
      wr(8'h00, p);           exp_out = p;              chk_state("R2 full write");
      wr(8'h04, ~p & 32'h0F0F_F0F0); exp_out |= (~p & 32'h0F0F_F0F0); chk_state("R3 set");
      wr(8'h08, p ^ 32'h3333_CCCC);  exp_out &= ~(p ^ 32'h3333_CCCC); chk_state("R4 clear");
      wr(8'h0C, p + 32'h1357_9BDF);  exp_out ^= (p + 32'h1357_9BDF);  chk_state("R5 toggle");
      wr(8'h14, p * 32'd7);   exp_dir = p * 32'd7;      chk_state("R8 direction");
    end

    // R3/R4/R5 walking single bits leave others alone
    wr(8'h00, 32'hA5A5_5A5A); exp_out = 32'hA5A5_5A5A;
    for (int b = 0; b < 32; b++) begin
      wr(8'h0C, 32'h1 << b); exp_out ^= (32'h1 << b); chk_state("R5 walk toggle");
      wr(8'h04, 32'h1 << b); exp_out |= (32'h1 << b); chk_state("R3 walk set");
      wr(8'h08, 32'h1 << ((b + 5) % 32)); exp_out &= ~(32'h1 << ((b + 5) % 32)); chk_state("R4 walk clear");
    end

    // R6: aliases read zero while the latch is nonzero
    wr(8'h00, 32'hFFFF_FFFF); exp_out = 32'hFFFF_FFFF;
    rd(8'h04, v); chk("R6 read 0x04", v, '0);
    rd(8'h08, v); chk("R6 read 0x08", v, '0);
    rd(8'h0C, v); chk("R6 read 0x0C", v, '0);

    // R7: two-edge synchroniser latency
    for (int i = 0; i < 8; i++) begin
      logic [31:0] old_in;
      old_in = pin_in;
      p = 32'hC0DE_0000 ^ (i * 32'h0101_1111);
      @(negedge clk);
      bus_addr = 8'h10; pin_in = p;
      @(negedge clk); #1; chk("R7 after one edge", bus_rdata, old_in);
      @(negedge clk); #1; chk("R7 after two edges", bus_rdata, p);
    end
    wr(8'h10, 32'h1234_5678);
    chk_state("R7 write to input ignored");

    // R9: every undecoded address reads zero and ignores writes
    for (int a = 0; a < 256; a++) begin
      if (!((a[1:0] == 2'b00) && (a < 8'h18))) begin
        wr(8'(a), 32'h5555_AAAA ^ a);
        rd(8'(a), v); chk("R9 undefined read", v, '0);
        chk("R9 out unchanged", pin_out, exp_out);
        chk("R9 oe unchanged",  pin_oe,  exp_dir);
      end
    end

    // R10: no write, nothing moves, even with wdata and addr active
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    bus_addr = 8'h14;
    repeat (3) @(negedge clk);
    chk_state("R10 idle hold");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule